// File: doc/BRIEF.md
# Run-Mode Clock-Enable Generator

This block drives every register of a three-domain subsystem from one fast clock, of frequency f. It does this by producing one-cycle enable strobes that set how often each domain may update. The high-criticality domain updates on every fast cycle. The medium-criticality and low-criticality domains update at a rate set by the selected run mode. In the deepest power mode the low-criticality rate is a programmable divisor k. For each pair of domains there is also a transfer strobe. Registers that capture data crossing between the pair use it, so a crossing path gets as many fast cycles to settle as the slower domain's divide ratio.

Each divided strobe comes from a small two-state counter machine. State `DV_FIRE` raises the strobe for one cycle and loads the next period. The `FIRE->FIRE` transition is taken when the ratio is 1, and the `FIRE->COUNT` transition is taken otherwise. State `DV_COUNT` counts down. It takes `COUNT->COUNT` while the count is above one and `COUNT->FIRE` when the count reaches one. A new mode or divisor is picked up only at a `DV_FIRE` cycle, so a period already under way is never cut short.

When the medium and low domains both run at f/2, the medium counter chooses its reload so that its strobe lands in the same cycle as the low-domain strobe. This can stretch one medium period to three cycles.

Top module: `rmode_clken_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, every enable and transfer output is high, because all counters start at zero.
- R2: `en_hi` is high on every cycle.
- R3: With `run_mode` 2'b00 (full speed), or the spare code 2'b11 which behaves the same, `en_mid` is high every cycle and `en_lo` is high on every second cycle, counting from the first cycle after reset.
- R4: With `run_mode` 2'b01 (reduced), `en_mid` and `en_lo` are both high on every second cycle and fall in the same cycles.
- R5: With `run_mode` 2'b10 (deepest), `en_mid` is high every second cycle and `en_lo` is high once every k cycles. k is `lo_div`, with values 0 to 2 treated as 3 and values 9 to 15 treated as 8.
- R6: Outside run_mode 2'b10, the value of `lo_div` has no effect on any output.
- R7: A change of mode or divisor takes effect at the next strobe of the affected domain. The interval that ends at that strobe keeps the old length, and the intervals after it use the new length.
- R8: `xfer_hi_mid` equals `en_mid`. `xfer_hi_lo` and `xfer_mid_lo` equal `en_lo`, since the low domain is never faster than the medium domain.
- R9: When the medium domain moves to a divide-by-2 rate while the low domain already runs at divide-by-2 but in the opposite phase, the medium domain waits three cycles once instead of two. From then on both strobes coincide. No medium interval is ever shorter than the active ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, frequency f |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_mode | input | 2 | 00 full speed, 01 reduced, 10 deepest, 11 spare (acts as 00) |
| lo_div | input | 4 | Low-domain divisor used in the deepest mode, clamped to 3..8 |
| en_hi | output | 1 | High-criticality domain enable |
| en_mid | output | 1 | Medium-criticality domain enable |
| en_lo | output | 1 | Low-criticality domain enable |
| xfer_hi_mid | output | 1 | Capture strobe for high/medium crossings |
| xfer_hi_lo | output | 1 | Capture strobe for high/low crossings |
| xfer_mid_lo | output | 1 | Capture strobe for medium/low crossings |

## Verification
Two mechanisms can act in the same cycle: a mode change being picked up at a medium-domain strobe, and the phase-alignment correction against the low-domain counter. The bench provokes this by switching from full speed to reduced mode on a cycle where the low domain is exactly one cycle from its strobe. It then checks that the medium strobe skips two cycles and lines up with the low strobe from then on. A separate case changes k in the middle of a low-domain period and checks that the interval then running keeps its old length.

// File: rtl/rmcg_pkg.sv
package rmcg_pkg;

    typedef enum logic [1:0] {
        RM_NORMAL = 2'b00,
        RM_LOWPWR = 2'b01,
        RM_ULTRA  = 2'b10,
        RM_SPARE  = 2'b11
    } run_mode_e;

    typedef enum logic {
        DV_FIRE  = 1'b0,
        DV_COUNT = 1'b1
    } div_state_e;

endpackage

// File: rtl/rmcg_ratio_sel.sv
module rmcg_ratio_sel
    import rmcg_pkg::*;
#(
    parameter int CW   = 4,
    parameter int KW   = 4,
    parameter int KMIN = 3,
    parameter int KMAX = 8
) (
    input  logic [1:0]    mode_i,
    input  logic [KW-1:0] k_i,
    output logic [CW-1:0] mid_ratio_o,
    output logic [CW-1:0] lo_ratio_o
);

    localparam logic [CW-1:0] ONE   = CW'(1);
    localparam logic [CW-1:0] TWO   = CW'(2);
    localparam logic [CW-1:0] K_LOW = CW'(KMIN);
    localparam logic [CW-1:0] K_TOP = CW'(KMAX);

    logic [CW-1:0] k_ext;
    logic [CW-1:0] k_clamped;
    run_mode_e     mode;

    assign mode  = run_mode_e'(mode_i);
    assign k_ext = CW'(k_i);

    // clamp divisor into the supported window
    always_comb begin
        if (k_ext < K_LOW) begin
            k_clamped = K_LOW;
        end else if (k_ext > K_TOP) begin
            k_clamped = K_TOP;
        end else begin
            k_clamped = k_ext;
        end
    end

    always_comb begin
        unique case (mode)
            RM_NORMAL, RM_SPARE: begin
                mid_ratio_o = ONE;
                lo_ratio_o  = TWO;
            end
            RM_LOWPWR: begin
                mid_ratio_o = TWO;
                lo_ratio_o  = TWO;
            end
            RM_ULTRA: begin
                mid_ratio_o = TWO;
                lo_ratio_o  = k_clamped;
            end
        endcase
    end

endmodule

// File: rtl/rmcg_div.sv
module rmcg_div
    import rmcg_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] reload_i,
    output logic          fire_o,
    output logic [CW-1:0] cnt_o
);

    localparam logic [CW-1:0] ZERO = '0;
    localparam logic [CW-1:0] ONE  = CW'(1);

    div_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= DV_FIRE;
            cnt_q <= ZERO;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            DV_FIRE: begin
                if (reload_i == ZERO) begin
                    st_d  = DV_FIRE;
                    cnt_d = ZERO;
                end else begin
                    st_d  = DV_COUNT;
                    cnt_d = reload_i;
                end
            end
            DV_COUNT: begin
                cnt_d = cnt_q - ONE;
                if (cnt_q == ONE) begin
                    st_d = DV_FIRE;
                end else begin
                    st_d = DV_COUNT;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        fire_o = (st_q == DV_FIRE);
        cnt_o  = cnt_q;
    end

endmodule

// File: rtl/rmode_clken_gen.sv
module rmode_clken_gen
    import rmcg_pkg::*;
#(
    parameter int CW   = 4,
    parameter int KW   = 4,
    parameter int KMIN = 3,
    parameter int KMAX = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    run_mode,
    input  logic [KW-1:0] lo_div,
    output logic          en_hi,
    output logic          en_mid,
    output logic          en_lo,
    output logic          xfer_hi_mid,
    output logic          xfer_hi_lo,
    output logic          xfer_mid_lo
);

    localparam logic [CW-1:0] ZERO = '0;
    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW-1:0] TWO  = CW'(2);

    logic [CW-1:0] mid_ratio, lo_ratio;
    logic [CW-1:0] mid_reload, lo_reload;
    logic [CW-1:0] mid_cnt, lo_cnt;
    logic [CW-1:0] lo_ratio_q;
    logic [CW-1:0] lo_next_cnt, lo_next_ratio;
    logic          mid_fire, lo_fire;

    rmcg_ratio_sel #(
        .CW   (CW),
        .KW   (KW),
        .KMIN (KMIN),
        .KMAX (KMAX)
    ) ratio_i (
        .mode_i      (run_mode),
        .k_i         (lo_div),
        .mid_ratio_o (mid_ratio),
        .lo_ratio_o  (lo_ratio)
    );

    // ratio governing the low-domain period now running
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_ratio_q <= TWO;
        end else if (lo_fire) begin
            lo_ratio_q <= lo_ratio;
        end
    end

    assign lo_reload = lo_ratio - ONE;

    // low-domain count and ratio one cycle ahead
    always_comb begin
        if (lo_fire) begin
            lo_next_cnt   = lo_reload;
            lo_next_ratio = lo_ratio;
        end else begin
            lo_next_cnt   = lo_cnt - ONE;
            lo_next_ratio = lo_ratio_q;
        end
    end

    // medium reload: phase-lock to the low domain when both divide by 2
    always_comb begin
        if (mid_ratio == TWO && lo_next_ratio == TWO) begin
            mid_reload = (lo_next_cnt == ZERO) ? TWO : ONE;
        end else begin
            mid_reload = mid_ratio - ONE;
        end
    end

    rmcg_div #(.CW(CW)) mid_div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload_i (mid_reload),
        .fire_o   (mid_fire),
        .cnt_o    (mid_cnt)
    );

    rmcg_div #(.CW(CW)) lo_div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload_i (lo_reload),
        .fire_o   (lo_fire),
        .cnt_o    (lo_cnt)
    );

    logic mid_cnt_unused;
    assign mid_cnt_unused = |mid_cnt;

    always_comb begin
        en_hi       = 1'b1;
        en_mid      = mid_fire;
        en_lo       = lo_fire;
        xfer_hi_mid = mid_fire;
        xfer_hi_lo  = lo_fire;
        xfer_mid_lo = lo_fire;
    end

endmodule

// File: rtl/rmode_clken_gen_chk.sv
module rmode_clken_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] run_mode,
    input logic       en_mid,
    input logic       en_lo
);

    logic       first_q;
    logic [3:0] gap_q;
    logic [4:0] lp_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q  <= 1'b1;
            gap_q    <= '0;
            lp_run_q <= '0;
        end else begin
            first_q <= 1'b0;
            if (en_lo) begin
                gap_q <= '0;
            end else if (gap_q != 4'hF) begin
                gap_q <= gap_q + 4'd1;
            end
            if (run_mode != 2'b01) begin
                lp_run_q <= '0;
            end else if (lp_run_q != 5'h1F) begin
                lp_run_q <= lp_run_q + 5'd1;
            end
        end
    end

    // R1
    first_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_q |-> (en_mid && en_lo));

    // R3
    mid_full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_mid && (run_mode == 2'b00 || run_mode == 2'b11)) |=> en_mid);

    // R4
    mid_half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_mid && (run_mode == 2'b01 || run_mode == 2'b10)) |=> !en_mid);

    // R4
    lo_half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_lo && run_mode != 2'b10) |=> !en_lo);

    // R5
    lo_max_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q == 4'd7) |-> en_lo);

    // R9
    phase_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_run_q >= 5'd16) |-> (en_mid == en_lo));

endmodule

bind rmode_clken_gen rmode_clken_gen_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_mode (run_mode),
    .en_mid   (en_mid),
    .en_lo    (en_lo)
);

// File: tb/rmode_clken_gen_tb_top.sv
module rmode_clken_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode;
    logic [3:0] kdiv;
    logic       en_hi, en_mid, en_lo, x_hm, x_hl, x_ml;

    int errs   = 0;
    int checks = 0;

    always #5 clk = ~clk;

    rmode_clken_gen dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_mode    (mode),
        .lo_div      (kdiv),
        .en_hi       (en_hi),
        .en_mid      (en_mid),
        .en_lo       (en_lo),
        .xfer_hi_mid (x_hm),
        .xfer_hi_lo  (x_hl),
        .xfer_mid_lo (x_ml)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampk(input int k);
        if (k < 3) return 3;
        if (k > 8) return 8;
        return k;
    endfunction

    function automatic int mid_ratio(input int m);
        return (m == 1 || m == 2) ? 2 : 1;
    endfunction

    function automatic int lo_ratio(input int m, input int k);
        return (m == 2) ? clampk(k) : 2;
    endfunction

    task automatic reset_dut;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // per-cycle check of all outputs for a steady configuration
    task automatic check_cycle(input string req, input int n, input int rm, input int rl);
        chk("R2", int'(en_hi), 1);
        chk(n == 0 ? "R1" : req, int'({en_mid, en_lo}),
            int'({(n % rm == 0), (n % rl == 0)}));
        chk("R8", int'({x_hm, x_hl, x_ml}),
            int'({(n % rm == 0), (n % rl == 0), (n % rl == 0)}));
    endtask

    initial begin
        rst_n = 1'b0;
        mode  = 2'b00;
        kdiv  = 4'd0;
        @(negedge clk);
        // R1: held high while in reset
        chk("R1", int'({en_hi, en_mid, en_lo, x_hm, x_hl, x_ml}), 63);

        // sweep every mode and every divisor code from reset
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 16; k++) begin
                string tag;
                mode = 2'(m);
                kdiv = 4'(k);
                tag  = (m == 1) ? "R4" : (m == 2) ? "R5" : "R3";
                reset_dut();
                for (int n = 0; n < 24; n++) begin
                    check_cycle(tag, n, mid_ratio(m), lo_ratio(m, k));
                    @(negedge clk);
                end
            end
        end

        // R6: divisor wiggling outside the deepest mode
        for (int m = 0; m < 2; m++) begin
            mode = 2'(m);
            kdiv = 4'd0;
            reset_dut();
            for (int n = 0; n < 32; n++) begin
                check_cycle("R6", n, mid_ratio(m), 2);
                kdiv = 4'((n * 7 + 3) % 16);
                @(negedge clk);
            end
        end

        // R7: k 5 -> 3 in mid-period; the running interval keeps length 5
        mode = 2'b10;
        kdiv = 4'd5;
        reset_dut();
        for (int n = 0; n < 22; n++) begin
            int exp_lo;
            exp_lo = (n <= 10) ? int'(n % 5 == 0) : int'((n - 10) % 3 == 0);
            chk("R7", int'(en_lo), exp_lo);
            chk("R7", int'(en_mid), int'(n % 2 == 0));
            if (n == 7) kdiv = 4'd3;
            @(negedge clk);
        end

        // R9: full speed -> reduced while low domain is one cycle from its strobe
        mode = 2'b00;
        kdiv = 4'd0;
        reset_dut();
        for (int n = 0; n < 16; n++) begin
            int exp_mid;
            exp_mid = (n <= 3) ? 1 : int'(n >= 6 && n % 2 == 0);
            chk("R9", int'(en_mid), exp_mid);
            chk("R9", int'(en_lo), int'(n % 2 == 0));
            if (n == 3) mode = 2'b01;
            @(negedge clk);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule